// File: doc/BRIEF.md
# Section-Mapped Address Translation Walker

This block turns 32-bit virtual addresses into physical addresses when memory is mapped only in 1 MB sections. A requester offers a virtual address through a valid/ready handshake. If translation is switched off, the address comes back unchanged and no memory read is made. If translation is on, the block builds the address of one first-level descriptor from the table base and the top twelve virtual-address bits. It then issues a single word read on a request/response memory port and decodes the word that returns. The result is either a physical address with its cacheable and bufferable attributes, or a fault code.

Three configuration registers are written through a small select/data port: the table base, the control word (only bit 0, the enable, is kept) and the domain access word. Only one walk is in flight at a time.

The controller has four states. `ST_IDLE` accepts a request. Acceptance leads to `ST_ISSUE` when translation is on, and straight to `ST_DONE` when it is off. `ST_ISSUE` holds the descriptor read until the memory accepts it, then moves to `ST_WAIT`. `ST_WAIT` moves to `ST_DONE` when the response arrives. `ST_DONE` presents the result for one cycle and always returns to `ST_IDLE`.

Top module: `sect_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_rd_valid` and `res_valid` are 0, and translation is disabled.
- R2: While the enable is 0, an accepted request returns `res_paddr` equal to the virtual address, with fault code 0, both attributes 0, and no memory read.
- R3: The descriptor read address is the table base, with its low 14 bits forced to zero, plus `VA[31:20]` times 4. The low 14 bits of a base write are ignored.
- R4: For a section descriptor that passes its checks, `res_paddr` is descriptor bits [31:20] joined with `VA[19:0]`. `res_cacheable` is descriptor bit 3 and `res_bufferable` is descriptor bit 2.
- R5: A descriptor whose bits [1:0] are not 10 (that is 00, 01 or 11) gives fault code 1 (translation fault).
- R6: The domain is descriptor bits [8:5]. Its 2-bit field sits at domain-word bits [2d+1:2d]. A field of 00 or 10 gives fault code 2 (domain fault).
- R7: With a domain field of 01 (client), descriptor bits [11:10] equal to 11 allow the access. Any other value gives fault code 3 (permission fault).
- R8: With a domain field of 11 (manager), the section is translated whatever its permission bits hold.
- R9: Only one walk is outstanding. `req_ready` stays low from acceptance until the result has been delivered. `mem_rd_valid` and `mem_rd_addr` hold steady until `mem_rd_ready` is seen.
- R10: The result appears as a one-cycle `res_valid` pulse. It comes in the cycle after the response is captured, or in the cycle after acceptance for a bypassed request.
- R11: Configuration select 0 writes the base, 1 the control word and 2 the domain word. Only control bit 0 has an effect, and select 3 changes nothing.
- R12: On any fault, `res_paddr` and both attributes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 base, 1 control, 2 domain word |
| cfg_wr_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result strobe (one cycle) |
| res_paddr | output | 32 | Physical address, 0 on fault |
| res_fault_code | output | 2 | 0 none, 1 translation, 2 domain, 3 permission |
| res_cacheable | output | 1 | Cacheable attribute of the section |
| res_bufferable | output | 1 | Bufferable attribute of the section |

## Verification
Directed cases come first. They cover a base written with its low bits set, the top table index, every non-section type code, and each of the four domain-field values. Against the manager and client domains, permission codes are tried both permitted and refused. These separate address-formation errors from decode-priority errors, and translation faults from domain and permission faults. Next come several hundred random addresses and descriptors, mostly of section type and over randomly filled domain words. Memory acceptance and response delays also vary at random, which exposes handshake-hold and one-outstanding violations. Bypass is checked both before enabling and after disabling, and writes to control bits other than bit 0 and to the spare select are checked for no effect.

// File: rtl/sxw_pkg.sv
package sxw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_XLATE  = 2'd1,
        FLT_DOMAIN = 2'd2,
        FLT_PERM   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        fault_e fault;
        logic   cacheable;
        logic   bufferable;
    } xlate_attr_t;

    localparam logic [1:0] DESC_TYPE_SECTION = 2'b10;
    localparam logic [1:0] DOM_MANAGER       = 2'b11;
    localparam logic [1:0] DOM_CLIENT        = 2'b01;
    localparam logic [1:0] AP_ALLOW          = 2'b11;

    localparam logic [1:0] CFG_SEL_BASE = 2'd0;
    localparam logic [1:0] CFG_SEL_CTRL = 2'd1;
    localparam logic [1:0] CFG_SEL_DOM  = 2'd2;

endpackage

// File: rtl/sxw_cfg_regs.sv
module sxw_cfg_regs
    import sxw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 14,
    parameter int NUM_DOM = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [ADDR_W-1:0]    wr_data,
    output logic [ADDR_W-1:0]    tbase,
    output logic                 xlate_en,
    output logic [2*NUM_DOM-1:0] dom_ctrl
);
    localparam int DOM_W = 2 * NUM_DOM;

    logic [ADDR_W-ALIGN_W-1:0] base_hi_q;
    logic                      en_q;
    logic [DOM_W-1:0]          dom_q;

    logic unused_wr_low;
    assign unused_wr_low = ^wr_data[ALIGN_W-1:1];

    // R11: select 3 falls through and leaves every register untouched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi_q <= '0;
            en_q      <= 1'b0;
            dom_q     <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                CFG_SEL_BASE: base_hi_q <= wr_data[ADDR_W-1:ALIGN_W];
                CFG_SEL_CTRL: en_q      <= wr_data[0];
                CFG_SEL_DOM:  dom_q     <= wr_data[DOM_W-1:0];
                default:      ;
            endcase
        end
    end

    assign tbase    = {base_hi_q, {ALIGN_W{1'b0}}};
    assign xlate_en = en_q;
    assign dom_ctrl = dom_q;

endmodule

// File: rtl/sxw_sect_decode.sv
module sxw_sect_decode
    import sxw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SECT_W  = 20,
    parameter int NUM_DOM = 16
) (
    input  logic [ADDR_W-1:0]    desc,
    input  logic [ADDR_W-1:0]    vaddr,
    input  logic [2*NUM_DOM-1:0] dom_ctrl,
    output logic [ADDR_W-1:0]    paddr,
    output xlate_attr_t          attr
);
    localparam int DOM_IDX_W = $clog2(NUM_DOM);
    localparam int DOM_LSB   = 5;
    localparam int AP_LSB    = 10;

    logic [DOM_IDX_W-1:0] dom_idx;
    logic [1:0]           dom_field;
    logic [1:0]           ap;
    fault_e               fault;

    logic unused_desc;
    assign unused_desc = ^{desc[SECT_W-1:AP_LSB+2], desc[AP_LSB-1:DOM_LSB+DOM_IDX_W], desc[4]};

    assign dom_idx   = desc[DOM_LSB +: DOM_IDX_W];
    assign dom_field = dom_ctrl[{dom_idx, 1'b0} +: 2];
    assign ap        = desc[AP_LSB +: 2];

    always_comb begin
        if (desc[1:0] != DESC_TYPE_SECTION) begin
            fault = FLT_XLATE;
        end else begin
            unique case (dom_field)
                DOM_MANAGER: fault = FLT_NONE;
                DOM_CLIENT:  fault = (ap == AP_ALLOW) ? FLT_NONE : FLT_PERM;
                default:     fault = FLT_DOMAIN;
            endcase
        end
    end

    always_comb begin
        attr.fault = fault;
        if (fault == FLT_NONE) begin
            paddr           = {desc[ADDR_W-1:SECT_W], vaddr[SECT_W-1:0]};
            attr.cacheable  = desc[3];
            attr.bufferable = desc[2];
        end else begin
            paddr           = '0;
            attr.cacheable  = 1'b0;
            attr.bufferable = 1'b0;
        end
    end

endmodule

// File: rtl/sxw_walk_fsm.sv
module sxw_walk_fsm
    import sxw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SECT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic [ADDR_W-1:0] tbase,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [ADDR_W-1:0] cur_vaddr,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              cur_bypass
);
    localparam int IDX_W = ADDR_W - SECT_W;
    localparam int PAD_W = ADDR_W - IDX_W - 2;

    walk_state_e       state_q, state_nx;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] desc_q;
    logic              byp_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_nx = xlate_en ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_rd_ready)  state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:                     state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            desc_q  <= '0;
            byp_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE && req_valid) begin
                va_q  <= req_vaddr;
                byp_q <= !xlate_en;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                desc_q <= mem_rsp_data;
            end
        end
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_ISSUE);
        res_valid    = (state_q == ST_DONE);
        mem_rd_addr  = tbase + {{PAD_W{1'b0}}, va_q[ADDR_W-1:SECT_W], 2'b00};
        cur_vaddr    = va_q;
        cur_desc     = desc_q;
        cur_bypass   = byp_q;
    end

endmodule

// File: rtl/sect_xlate_walker.sv
module sect_xlate_walker
    import sxw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SECT_W  = 20,
    parameter int ALIGN_W = 14,
    parameter int NUM_DOM = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_paddr,
    output logic [1:0]        res_fault_code,
    output logic              res_cacheable,
    output logic              res_bufferable
);
    logic [ADDR_W-1:0]    tbase;
    logic                 xlate_en;
    logic [2*NUM_DOM-1:0] dom_ctrl;
    logic [ADDR_W-1:0]    cur_vaddr;
    logic [ADDR_W-1:0]    cur_desc;
    logic                 cur_bypass;
    logic [ADDR_W-1:0]    dec_paddr;
    xlate_attr_t          dec_attr;

    sxw_cfg_regs #(
        .ADDR_W (ADDR_W),
        .ALIGN_W(ALIGN_W),
        .NUM_DOM(NUM_DOM)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .tbase   (tbase),
        .xlate_en(xlate_en),
        .dom_ctrl(dom_ctrl)
    );

    sxw_walk_fsm #(
        .ADDR_W(ADDR_W),
        .SECT_W(SECT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .xlate_en     (xlate_en),
        .tbase        (tbase),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .res_valid    (res_valid),
        .cur_vaddr    (cur_vaddr),
        .cur_desc     (cur_desc),
        .cur_bypass   (cur_bypass)
    );

    sxw_sect_decode #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .NUM_DOM(NUM_DOM)
    ) u_dec (
        .desc    (cur_desc),
        .vaddr   (cur_vaddr),
        .dom_ctrl(dom_ctrl),
        .paddr   (dec_paddr),
        .attr    (dec_attr)
    );

    always_comb begin
        if (cur_bypass) begin
            res_paddr      = cur_vaddr;
            res_fault_code = FLT_NONE;
            res_cacheable  = 1'b0;
            res_bufferable = 1'b0;
        end else begin
            res_paddr      = dec_paddr;
            res_fault_code = dec_attr.fault;
            res_cacheable  = dec_attr.cacheable;
            res_bufferable = dec_attr.bufferable;
        end
    end

endmodule

// File: rtl/sxw_walk_checker.sv
module sxw_walk_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_paddr,
    input logic [1:0]        res_fault_code,
    input logic              res_cacheable,
    input logic              res_bufferable
);
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_busy_during_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

    assert_fault_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault_code != 2'd0) |->
            (res_paddr == '0 && !res_cacheable && !res_bufferable));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_ready_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> req_ready);

endmodule

bind sect_xlate_walker sxw_walk_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault_code(res_fault_code),
    .res_cacheable (res_cacheable),
    .res_bufferable(res_bufferable)
);

// File: tb/sect_xlate_walker_tb.sv
module sect_xlate_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic [1:0]  res_fault_code;
    logic        res_cacheable;
    logic        res_bufferable;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [31:0] m_base = '0;
    logic        m_en   = 1'b0;
    logic [31:0] m_dacr = '0;

    always #5 clk = ~clk;

    sect_xlate_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_fault_code(res_fault_code),
        .res_cacheable(res_cacheable), .res_bufferable(res_bufferable)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] va, input logic [31:0] desc,
                                  input logic [31:0] dacr, output logic [31:0] pa,
                                  output logic [1:0] code, output logic c, output logic b);
        logic [3:0] dom;
        logic [1:0] fld;
        dom  = desc[8:5];
        fld  = 2'((dacr >> (2 * dom)) & 32'h3);
        code = 2'd0;
        if (desc[1:0] != 2'b10)      code = 2'd1;
        else if (fld == 2'b01)       code = (desc[11:10] == 2'b11) ? 2'd0 : 2'd3;
        else if (fld != 2'b11)       code = 2'd2;
        if (code == 2'd0) begin
            pa = {desc[31:20], va[19:0]};
            c  = desc[3];
            b  = desc[2];
        end else begin
            pa = '0;
            c  = 1'b0;
            b  = 1'b0;
        end
    endfunction

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel == 2'd0) m_base = data & 32'hFFFF_C000;
        if (sel == 2'd1) m_en   = data[0];
        if (sel == 2'd2) m_dacr = data;
    endtask

    task automatic xlate(input logic [31:0] va, input logic [31:0] desc, input string tag);
        logic [31:0] e_pa;
        logic [1:0]  e_code;
        logic        e_c, e_b;
        logic [31:0] e_addr;
        int          dly;
        model(va, desc, m_dacr, e_pa, e_code, e_c, e_b);
        e_addr = m_base + {18'd0, va[31:20], 2'b00};
        @(negedge clk);
        chk({tag, " R9 ready when idle"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (!m_en) begin
            chk({tag, " R2 no read in bypass"}, 32'(mem_rd_valid), 32'd0);
            chk({tag, " R10 bypass result strobe"}, 32'(res_valid), 32'd1);
            chk({tag, " R2 bypass paddr"}, res_paddr, va);
            chk({tag, " R2 bypass code/attrs"}, {28'd0, res_fault_code, res_cacheable, res_bufferable}, 32'd0);
        end else begin
            chk({tag, " R9 read issued"}, 32'(mem_rd_valid), 32'd1);
            chk({tag, " R3 descriptor address"}, mem_rd_addr, e_addr);
            chk({tag, " R9 busy while reading"}, 32'(req_ready), 32'd0);
            dly = int'($urandom % 3);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk({tag, " R9 read held"}, {31'd0, mem_rd_valid}, 32'd1);
                chk({tag, " R9 address held"}, mem_rd_addr, e_addr);
            end
            mem_rd_ready = 1'b1;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            chk({tag, " R9 single read"}, 32'(mem_rd_valid), 32'd0);
            dly = int'($urandom % 3);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk({tag, " R10 no early result"}, 32'(res_valid), 32'd0);
                chk({tag, " R9 busy awaiting data"}, 32'(req_ready), 32'd0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = desc;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk({tag, " R10 result strobe"}, 32'(res_valid), 32'd1);
            chk({tag, " R4 paddr"}, res_paddr, e_pa);
            chk({tag, " R5/R6/R7 fault code"}, 32'(res_fault_code), 32'(e_code));
            chk({tag, " R4 attrs"}, {30'd0, res_cacheable, res_bufferable}, {30'd0, e_c, e_b});
            if (e_code != 2'd0)
                chk({tag, " R12 cleared on fault"}, res_paddr, 32'd0);
        end
        @(negedge clk);
        chk({tag, " R10 strobe one cycle"}, 32'(res_valid), 32'd0);
        chk({tag, " R9 ready again"}, 32'(req_ready), 32'd1);
    endtask

    function automatic logic [31:0] sect(input logic [11:0] hi, input logic [1:0] ap,
                                         input logic [3:0] dom, input logic c, input logic b);
        return {hi, 8'd0, ap, 1'b0, dom, 1'b1, c, b, 2'b10};
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R1 reset no read", 32'(mem_rd_valid), 32'd0);
        chk("R1 reset no result", 32'(res_valid), 32'd0);
        xlate(32'hA000_0010, 32'h5600_0C1E, "R1 disabled after reset");
        xlate(32'h1234_5678, 32'hFFFF_FFFF, "R2 bypass");

        cfg(2'd3, 32'h0000_0001);
        xlate(32'hA000_0014, 32'h5600_0C1E, "R11 select 3 ignored");
        cfg(2'd1, 32'hFFFF_FFFE);
        xlate(32'h3000_0000, 32'h5600_0C1E, "R11 control upper bits ignored");

        cfg(2'd0, 32'h3000_3FFF);
        cfg(2'd2, 32'hFFFF_FFFF);
        cfg(2'd1, 32'h0000_0001);
        xlate(32'hA000_0010, sect(12'h560, 2'b11, 4'd0, 1'b0, 1'b0), "R3/R4 low base bits");
        xlate(32'hFFFF_FFFF, sect(12'hABC, 2'b00, 4'd9, 1'b1, 1'b1), "R3 top index");
        xlate(32'h3001_2345, sect(12'h300, 2'b11, 4'd0, 1'b1, 1'b0), "R4 cacheable only");
        xlate(32'h4000_0000, 32'h5600_0C10, "R5 type 00");
        xlate(32'h4010_0000, 32'h5600_0C11, "R5 type 01");
        xlate(32'h4020_0000, 32'h5600_0C13, "R5 type 11");

        d = 32'hFFFF_FFFF;
        d[7:6] = 2'b00; d[9:8] = 2'b10; d[11:10] = 2'b01;
        cfg(2'd2, d);
        xlate(32'h5000_0100, sect(12'h111, 2'b11, 4'd3, 1'b1, 1'b1), "R6 field 00");
        xlate(32'h5010_0100, sect(12'h222, 2'b11, 4'd4, 1'b1, 1'b1), "R6 field 10");
        xlate(32'h5020_0100, sect(12'h333, 2'b01, 4'd5, 1'b1, 1'b1), "R7 client refused");
        xlate(32'h5030_0100, sect(12'h444, 2'b11, 4'd5, 1'b0, 1'b1), "R7 client allowed");
        xlate(32'h5040_0100, sect(12'h555, 2'b00, 4'd7, 1'b1, 1'b0), "R8 manager ap 00");
        xlate(32'h5050_0100, sect(12'h666, 2'b10, 4'd7, 1'b1, 1'b1), "R8 manager ap 10");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] va, ds;
            if (n % 50 == 0) cfg(2'd2, $urandom);
            if (n % 97 == 0) cfg(2'd0, $urandom);
            va = $urandom;
            ds = $urandom;
            if ($urandom % 4 != 0) ds[1:0] = 2'b10;
            xlate(va, ds, "R4 random walk");
        end

        cfg(2'd1, 32'h0000_0000);
        for (int n = 0; n < 20; n++) xlate($urandom, $urandom, "R2 random bypass");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule